// File: doc/BRIEF.md
# Supervisor interrupt view mapper

This block gives the lower privilege views of the machine interrupt-enable and interrupt-pending words. A processor's control-register unit sends it one access at a time. An access names a view (machine, supervisor, hypervisor or virtual supervisor), says whether it targets the enable word or the pending word, and carries write data and a per-bit write mask. The block returns the value that view reads. It also returns the new machine enable or pending word, with a write strobe that the register owner applies at the next clock edge.

The block uses the standard interrupt bit layout, and it depends on that layout: each cause has a user, supervisor, virtual-supervisor and machine copy, at adjacent positions. While guest execution is active, the supervisor view is moved up by one bit, so the guest reads and writes the virtual-supervisor bits at the supervisor positions. Every write is limited by the delegation word, by a fixed set of writable bits for each view, and, for pending bits, by the set of bits that hardware owns. The block holds no state, and every access resolves in the cycle it is presented.

Bit positions, from bit 0 upward, are user, supervisor, virtual-supervisor and machine software interrupts (bits 0 to 3), then the four timer interrupts in the same order (bits 4 to 7), then the four external interrupts (bits 8 to 11). The resulting masks are: supervisor set 0x222, virtual-supervisor set 0x444, machine set 0x888, delegable set 0x666, and supervisor-pending writable set 0x103. `req_view` encodes machine as 0, supervisor as 1, hypervisor as 2 and virtual supervisor as 3. `req_pend` is 0 for the enable word and 1 for the pending word. Wherever a requirement says a value is merged, the merged value is (read value AND NOT mask) OR (data AND mask).

Top module: `irq_view_mapper`

## Requirements
- R1: For a supervisor enable access (view 1, req_pend 0) with virt_on low, rd_data is m_ie AND m_deleg.
- R2: For a supervisor enable access with virt_on high, rd_data is (m_ie AND m_deleg AND 0x444) shifted right by one.
- R3: A supervisor enable write merges the data into the R1 or R2 read value. With virt_on low, bits 0x222 of ie_next take the merged value and all other bits keep m_ie. With virt_on high, the merged value is shifted left by one, bits 0x444 take it and all other bits keep m_ie.
- R4: A machine pending access (view 0, req_pend 1) returns m_ip from before the update. It writes req_wdata only into the bits of req_wmask AND 0x666 AND NOT hw_claim. Every other bit of ip_next keeps m_ip.
- R5: A supervisor pending access with virt_on low returns m_ip AND m_deleg. Its write mask is req_wmask AND m_deleg AND 0x103, then limited as in R4. This means only bit 1 can change.
- R6: A supervisor pending access with virt_on high returns (m_ip AND m_deleg AND 0x444) shifted right by one. Its write data and its mask (req_wmask AND 0x103) are shifted left by one, ANDed with m_deleg, then limited as in R4.
- R7: A hypervisor access (view 2) reads and writes only bits 0x444. The enable read value is m_ie AND 0x444, and an enable write replaces only those bits with the merged value. A pending write may change only bits 0x444 (also limited as in R4), and a pending read returns m_ip.
- R8: A virtual-supervisor access (view 3) returns m_ie AND m_deleg AND 0x444 for the enable word and m_ip for the pending word. An enable write changes only the bits in m_deleg AND 0x444. A pending write may change only bit 2 and only when bit 2 of m_deleg is set (also limited as in R4).
- R9: A machine enable access returns m_ie. Its write merges the data and changes only bits 0xEEE.
- R10: ie_we and ip_we are never high together. A strobe rises only while req_valid is high and at least one bit would be written. When its strobe is low, ie_next equals m_ie and ip_next equals m_ip. While req_valid is low, rd_data is zero.
- R11: When the block is built without hypervisor support (HAS_HYP = 0), virt_on has no effect. Hypervisor and virtual-supervisor accesses then read zero and never raise a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_valid | input | 1 | An access is presented this cycle |
| req_view | input | 2 | Accessing view: 0 machine, 1 supervisor, 2 hypervisor, 3 virtual supervisor |
| req_pend | input | 1 | 0 targets the enable word, 1 targets the pending word |
| req_wdata | input | XLEN | Write data of the read-modify-write |
| req_wmask | input | XLEN | Per-bit write mask; zero means a pure read |
| virt_on | input | 1 | Guest execution is active |
| m_ie | input | XLEN | Current machine interrupt-enable word |
| m_ip | input | XLEN | Current machine interrupt-pending word |
| m_deleg | input | XLEN | Machine interrupt delegation word |
| hw_claim | input | XLEN | Pending bits owned by hardware sources |
| rd_data | output | XLEN | Value read by the accessing view |
| ie_we | output | 1 | Load ie_next into the enable word |
| ie_next | output | XLEN | Next machine interrupt-enable word |
| ip_we | output | 1 | Load ip_next into the pending word |
| ip_next | output | XLEN | Next machine interrupt-pending word |

## Verification
Two cases are hard to reach from the ports. One is a pending write whose every masked bit is removed by the delegation word, the per-view writable set or the hardware-claimed mask: the strobe must stay low even though the request carries a non-zero mask. The other is the shifted guest view, where a single wrong shift direction can still produce plausible values. The vector table reaches both by choosing delegation words that differ between the supervisor and virtual-supervisor positions, asymmetric enable patterns such as 0x6E4, and claim masks that cover part or all of the delegable set. A second instance built without hypervisor support gets the same guest-mode stimulus, to show that the shift and the extra views are absent.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

   typedef enum logic [1:0] {
      VIEW_M  = 2'd0,
      VIEW_S  = 2'd1,
      VIEW_H  = 2'd2,
      VIEW_VS = 2'd3
   } view_e;

   localparam int unsigned IRQ_BITS = 12;

   // bit positions of the interrupt causes
   localparam int unsigned POS_USW = 0;
   localparam int unsigned POS_SSW = 1;
   localparam int unsigned POS_VSW = 2;
   localparam int unsigned POS_MSW = 3;
   localparam int unsigned POS_UTM = 4;
   localparam int unsigned POS_STM = 5;
   localparam int unsigned POS_VTM = 6;
   localparam int unsigned POS_MTM = 7;
   localparam int unsigned POS_UEX = 8;
   localparam int unsigned POS_SEX = 9;
   localparam int unsigned POS_VEX = 10;
   localparam int unsigned POS_MEX = 11;

   localparam logic [IRQ_BITS-1:0] ONE = IRQ_BITS'(1);

   localparam logic [IRQ_BITS-1:0] SUP_SET  = (ONE << POS_SSW) | (ONE << POS_STM) | (ONE << POS_SEX);
   localparam logic [IRQ_BITS-1:0] VSUP_SET = (ONE << POS_VSW) | (ONE << POS_VTM) | (ONE << POS_VEX);
   localparam logic [IRQ_BITS-1:0] MACH_SET = (ONE << POS_MSW) | (ONE << POS_MTM) | (ONE << POS_MEX);
   localparam logic [IRQ_BITS-1:0] DELEG_SET = SUP_SET | VSUP_SET;
   localparam logic [IRQ_BITS-1:0] ALL_SET  = DELEG_SET | MACH_SET;
   localparam logic [IRQ_BITS-1:0] SPEND_WR = (ONE << POS_SSW) | (ONE << POS_USW) | (ONE << POS_UEX);
   localparam logic [IRQ_BITS-1:0] VSSW_BIT = ONE << POS_VSW;

endpackage

// File: rtl/irqv_merge.sv
module irqv_merge #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] wmask,
   output logic [W-1:0] merged
);
   assign merged = (cur & ~wmask) | (wdata & wmask);
endmodule

// File: rtl/irqv_enable_path.sv
module irqv_enable_path
   import irqv_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter bit          HAS_HYP = 1'b1
) (
   input  logic            active,
   input  view_e           view,
   input  logic            virt_on,
   input  logic [XLEN-1:0] m_ie,
   input  logic [XLEN-1:0] m_deleg,
   input  logic [XLEN-1:0] wdata,
   input  logic [XLEN-1:0] wmask,
   output logic [XLEN-1:0] rd,
   output logic            we,
   output logic [XLEN-1:0] next
);
   localparam logic [XLEN-1:0] SUP_W  = XLEN'(SUP_SET);
   localparam logic [XLEN-1:0] VSUP_W = XLEN'(VSUP_SET);
   localparam logic [XLEN-1:0] ALL_W  = XLEN'(ALL_SET);

   logic            virt_eff;
   logic            hyp_ok;
   logic            view_ok;
   logic [XLEN-1:0] old_val;
   logic [XLEN-1:0] merged;
   logic [XLEN-1:0] cand;
   logic [XLEN-1:0] vs_sel;

   if (HAS_HYP) begin : g_hyp
      assign virt_eff = virt_on;
      assign hyp_ok   = 1'b1;
   end else begin : g_nohyp
      assign virt_eff = 1'b0;
      assign hyp_ok   = 1'b0;
   end

   assign view_ok = hyp_ok || (view == VIEW_M) || (view == VIEW_S);
   assign vs_sel  = m_deleg & VSUP_W;

   always_comb begin
      old_val = '0;
      case (view)
         VIEW_M:  old_val = m_ie;
         VIEW_S:  old_val = virt_eff ? ((m_ie & m_deleg & VSUP_W) >> 1) : (m_ie & m_deleg);
         VIEW_H:  old_val = hyp_ok ? (m_ie & VSUP_W) : '0;
         VIEW_VS: old_val = hyp_ok ? (m_ie & m_deleg & VSUP_W) : '0;
         default: old_val = '0;
      endcase
   end

   irqv_merge #(.W(XLEN)) u_merge (
      .cur    (old_val),
      .wdata  (wdata),
      .wmask  (wmask),
      .merged (merged)
   );

   always_comb begin
      cand = m_ie;
      case (view)
         VIEW_M:  cand = (m_ie & ~ALL_W) | (merged & ALL_W);
         VIEW_S: begin
            if (virt_eff) cand = (m_ie & ~VSUP_W) | ((merged << 1) & VSUP_W);
            else          cand = (m_ie & ~SUP_W) | (merged & SUP_W);
         end
         VIEW_H:  cand = (m_ie & ~VSUP_W) | (merged & VSUP_W);
         VIEW_VS: cand = (m_ie & ~vs_sel) | (merged & vs_sel);
         default: cand = m_ie;
      endcase
   end

   assign we   = active && view_ok && (wmask != '0);
   assign next = we ? cand : m_ie;
   assign rd   = old_val;
endmodule

// File: rtl/irqv_pending_path.sv
module irqv_pending_path
   import irqv_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter bit          HAS_HYP = 1'b1
) (
   input  logic            active,
   input  view_e           view,
   input  logic            virt_on,
   input  logic [XLEN-1:0] m_ip,
   input  logic [XLEN-1:0] m_deleg,
   input  logic [XLEN-1:0] hw_claim,
   input  logic [XLEN-1:0] wdata,
   input  logic [XLEN-1:0] wmask,
   output logic [XLEN-1:0] rd,
   output logic            we,
   output logic [XLEN-1:0] next
);
   localparam logic [XLEN-1:0] VSUP_W  = XLEN'(VSUP_SET);
   localparam logic [XLEN-1:0] DELEG_W = XLEN'(DELEG_SET);
   localparam logic [XLEN-1:0] SPWR_W  = XLEN'(SPEND_WR);
   localparam logic [XLEN-1:0] VSSW_W  = XLEN'(VSSW_BIT);

   logic            virt_eff;
   logic            hyp_ok;
   logic            view_ok;
   logic [XLEN-1:0] lim;
   logic [XLEN-1:0] wd;
   logic [XLEN-1:0] eff;
   logic [XLEN-1:0] merged;

   if (HAS_HYP) begin : g_hyp
      assign virt_eff = virt_on;
      assign hyp_ok   = 1'b1;
   end else begin : g_nohyp
      assign virt_eff = 1'b0;
      assign hyp_ok   = 1'b0;
   end

   assign view_ok = hyp_ok || (view == VIEW_M) || (view == VIEW_S);

   always_comb begin
      lim = '0;
      wd  = wdata;
      rd  = '0;
      case (view)
         VIEW_M: begin
            lim = wmask;
            rd  = m_ip;
         end
         VIEW_S: begin
            if (virt_eff) begin
               lim = ((wmask & SPWR_W) << 1) & m_deleg;
               wd  = wdata << 1;
               rd  = (m_ip & m_deleg & VSUP_W) >> 1;
            end else begin
               lim = wmask & m_deleg & SPWR_W;
               rd  = m_ip & m_deleg;
            end
         end
         VIEW_H: begin
            lim = hyp_ok ? (wmask & VSUP_W) : '0;
            rd  = hyp_ok ? m_ip : '0;
         end
         VIEW_VS: begin
            lim = hyp_ok ? (wmask & m_deleg & VSSW_W) : '0;
            rd  = hyp_ok ? m_ip : '0;
         end
         default: begin
            lim = '0;
            rd  = '0;
         end
      endcase
   end

   assign eff = lim & DELEG_W & ~hw_claim;

   irqv_merge #(.W(XLEN)) u_merge (
      .cur    (m_ip),
      .wdata  (wd),
      .wmask  (eff),
      .merged (merged)
   );

   assign we   = active && view_ok && (eff != '0);
   assign next = we ? merged : m_ip;
endmodule

// File: rtl/irq_view_mapper.sv
module irq_view_mapper
   import irqv_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter bit          HAS_HYP = 1'b1
) (
   input  logic            req_valid,
   input  logic [1:0]      req_view,
   input  logic            req_pend,
   input  logic [XLEN-1:0] req_wdata,
   input  logic [XLEN-1:0] req_wmask,
   input  logic            virt_on,
   input  logic [XLEN-1:0] m_ie,
   input  logic [XLEN-1:0] m_ip,
   input  logic [XLEN-1:0] m_deleg,
   input  logic [XLEN-1:0] hw_claim,
   output logic [XLEN-1:0] rd_data,
   output logic            ie_we,
   output logic [XLEN-1:0] ie_next,
   output logic            ip_we,
   output logic [XLEN-1:0] ip_next
);
   if (XLEN < IRQ_BITS) begin : g_width_check
      $error("irq_view_mapper: XLEN must cover the interrupt bit layout");
   end

   view_e           view;
   logic            en_act;
   logic            pd_act;
   logic [XLEN-1:0] en_rd;
   logic [XLEN-1:0] pd_rd;

   assign view   = view_e'(req_view);
   assign en_act = req_valid && !req_pend;
   assign pd_act = req_valid && req_pend;

   irqv_enable_path #(.XLEN(XLEN), .HAS_HYP(HAS_HYP)) u_en (
      .active  (en_act),
      .view    (view),
      .virt_on (virt_on),
      .m_ie    (m_ie),
      .m_deleg (m_deleg),
      .wdata   (req_wdata),
      .wmask   (req_wmask),
      .rd      (en_rd),
      .we      (ie_we),
      .next    (ie_next)
   );

   irqv_pending_path #(.XLEN(XLEN), .HAS_HYP(HAS_HYP)) u_pd (
      .active   (pd_act),
      .view     (view),
      .virt_on  (virt_on),
      .m_ip     (m_ip),
      .m_deleg  (m_deleg),
      .hw_claim (hw_claim),
      .wdata    (req_wdata),
      .wmask    (req_wmask),
      .rd       (pd_rd),
      .we       (ip_we),
      .next     (ip_next)
   );

   assign rd_data = !req_valid ? '0 : (req_pend ? pd_rd : en_rd);
endmodule

// File: rtl/irq_view_mapper_chk.sv
module irq_view_mapper_chk
   import irqv_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter bit          HAS_HYP = 1'b1
) (
   input logic            req_valid,
   input logic [1:0]      req_view,
   input logic            virt_on,
   input logic [XLEN-1:0] m_ie,
   input logic [XLEN-1:0] m_ip,
   input logic [XLEN-1:0] hw_claim,
   input logic [XLEN-1:0] rd_data,
   input logic            ie_we,
   input logic [XLEN-1:0] ie_next,
   input logic            ip_we,
   input logic [XLEN-1:0] ip_next
);
   localparam logic [XLEN-1:0] VSUP_W  = XLEN'(VSUP_SET);
   localparam logic [XLEN-1:0] MACH_W  = XLEN'(MACH_SET);
   localparam logic [XLEN-1:0] DELEG_W = XLEN'(DELEG_SET);
   localparam logic [XLEN-1:0] VSSW_W  = XLEN'(VSSW_BIT);

   always_comb begin
      AST_ONE_STROBE: assert (!(ie_we && ip_we)); // R10
      AST_IP_NONDELEG_HELD: assert (((ip_next ^ m_ip) & ~DELEG_W) == '0); // R4
      AST_IP_CLAIM_HELD: assert (((ip_next ^ m_ip) & hw_claim) == '0); // R4
      if (req_view != 2'd0) begin
         AST_IE_MBITS_HELD: assert (((ie_next ^ m_ie) & MACH_W) == '0); // R3
      end
      if (HAS_HYP && virt_on && req_view == 2'd1) begin
         AST_GUEST_S_VS_ONLY: assert (((ie_next ^ m_ie) & ~VSUP_W) == '0); // R3
      end
      if (req_view == 2'd3) begin
         AST_VS_PEND_BIT2_ONLY: assert (((ip_next ^ m_ip) & ~VSSW_W) == '0); // R8
      end
      if (!req_valid) begin
         AST_IDLE_QUIET: assert (!ie_we && !ip_we && rd_data == '0 && ie_next == m_ie && ip_next == m_ip); // R10
      end
   end
endmodule

bind irq_view_mapper irq_view_mapper_chk #(.XLEN(XLEN), .HAS_HYP(HAS_HYP)) u_chk (
   .req_valid (req_valid),
   .req_view  (req_view),
   .virt_on   (virt_on),
   .m_ie      (m_ie),
   .m_ip      (m_ip),
   .hw_claim  (hw_claim),
   .rd_data   (rd_data),
   .ie_we     (ie_we),
   .ie_next   (ie_next),
   .ip_we     (ip_we),
   .ip_next   (ip_next)
);

// File: tb/test_irq_view_mapper.sv
`timescale 1ns/1ps
module test_irq_view_mapper;
   localparam int unsigned XLEN = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic            req_valid;
   logic [1:0]      req_view;
   logic            req_pend;
   logic [XLEN-1:0] req_wdata, req_wmask;
   logic            virt_on;
   logic [XLEN-1:0] m_ie, m_ip, m_deleg, hw_claim;
   logic [XLEN-1:0] rd_data, ie_next, ip_next;
   logic            ie_we, ip_we;
   logic [XLEN-1:0] n_rd, n_ie_next, n_ip_next;
   logic            n_ie_we, n_ip_we;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   irq_view_mapper #(.XLEN(XLEN), .HAS_HYP(1'b1)) i_irq_view_mapper (
      .req_valid, .req_view, .req_pend, .req_wdata, .req_wmask, .virt_on,
      .m_ie, .m_ip, .m_deleg, .hw_claim,
      .rd_data, .ie_we, .ie_next, .ip_we, .ip_next
   );

   irq_view_mapper #(.XLEN(XLEN), .HAS_HYP(1'b0)) i_irq_view_mapper_nohyp (
      .req_valid, .req_view, .req_pend, .req_wdata, .req_wmask, .virt_on,
      .m_ie, .m_ip, .m_deleg, .hw_claim,
      .rd_data (n_rd), .ie_we (n_ie_we), .ie_next (n_ie_next),
      .ip_we (n_ip_we), .ip_next (n_ip_next)
   );

   typedef struct packed {
      logic [3:0]  tag;
      logic [1:0]  view;
      logic        pend;
      logic        virt;
      logic [11:0] ie, ip, dlg, clm, wd, wm, rd;
      logic        iewe;
      logic [11:0] ien;
      logic        ipwe;
      logic [11:0] ipn;
   } vec_t;

   localparam int NV = 21;
   // tag view pend virt  ie     ip     dlg    clm    wd     wm     rd   iewe ien  ipwe ipn
   localparam vec_t TAB [NV] = '{
      '{4'd1, 2'd1, 1'b0, 1'b0, 12'hFFF, 12'h000, 12'h222, 12'h000, 12'h000, 12'h000, 12'h222, 1'b0, 12'hFFF, 1'b0, 12'h000}, // R1
      '{4'd2, 2'd1, 1'b0, 1'b1, 12'h6E4, 12'h000, 12'h044, 12'h000, 12'h000, 12'h000, 12'h022, 1'b0, 12'h6E4, 1'b0, 12'h000}, // R2
      '{4'd3, 2'd1, 1'b0, 1'b0, 12'h888, 12'h000, 12'h222, 12'h000, 12'h222, 12'hFFF, 12'h000, 1'b1, 12'hAAA, 1'b0, 12'h000}, // R3
      '{4'd3, 2'd1, 1'b0, 1'b0, 12'h222, 12'h000, 12'h222, 12'h000, 12'h000, 12'h020, 12'h222, 1'b1, 12'h202, 1'b0, 12'h000}, // R3
      '{4'd3, 2'd1, 1'b0, 1'b1, 12'h222, 12'h000, 12'h444, 12'h000, 12'h222, 12'hFFF, 12'h000, 1'b1, 12'h666, 1'b0, 12'h000}, // R3
      '{4'd4, 2'd0, 1'b1, 1'b0, 12'h000, 12'h880, 12'h000, 12'h020, 12'hFFF, 12'hFFF, 12'h880, 1'b0, 12'h000, 1'b1, 12'hEC6}, // R4
      '{4'd5, 2'd1, 1'b1, 1'b0, 12'h000, 12'h000, 12'h222, 12'h000, 12'hFFF, 12'hFFF, 12'h000, 1'b0, 12'h000, 1'b1, 12'h002}, // R5
      '{4'd5, 2'd1, 1'b1, 1'b0, 12'h000, 12'h0A7, 12'h222, 12'h000, 12'h000, 12'h002, 12'h022, 1'b0, 12'h000, 1'b1, 12'h0A5}, // R5
      '{4'd6, 2'd1, 1'b1, 1'b1, 12'h000, 12'h000, 12'h444, 12'h000, 12'h002, 12'h002, 12'h000, 1'b0, 12'h000, 1'b1, 12'h004}, // R6
      '{4'd6, 2'd1, 1'b1, 1'b1, 12'h000, 12'h444, 12'h444, 12'h000, 12'h000, 12'h000, 12'h222, 1'b0, 12'h000, 1'b0, 12'h444}, // R6
      '{4'd7, 2'd2, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 12'h000, 12'hFFF, 12'hFFF, 12'h000, 1'b0, 12'h000, 1'b1, 12'h444}, // R7
      '{4'd7, 2'd2, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 12'h040, 12'hFFF, 12'hFFF, 12'h000, 1'b0, 12'h000, 1'b1, 12'h404}, // R7
      '{4'd7, 2'd2, 1'b0, 1'b0, 12'h888, 12'h000, 12'h000, 12'h000, 12'hFFF, 12'hFFF, 12'h000, 1'b1, 12'hCCC, 1'b0, 12'h000}, // R7
      '{4'd7, 2'd2, 1'b0, 1'b0, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h444, 1'b0, 12'hFFF, 1'b0, 12'h000}, // R7
      '{4'd8, 2'd3, 1'b1, 1'b0, 12'h000, 12'h000, 12'h444, 12'h000, 12'hFFF, 12'hFFF, 12'h000, 1'b0, 12'h000, 1'b1, 12'h004}, // R8
      '{4'd8, 2'd3, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 12'h000, 12'hFFF, 12'hFFF, 12'h000, 1'b0, 12'h000, 1'b0, 12'h000}, // R8
      '{4'd8, 2'd3, 1'b0, 1'b0, 12'hFFF, 12'h000, 12'h044, 12'h000, 12'h000, 12'h000, 12'h044, 1'b0, 12'hFFF, 1'b0, 12'h000}, // R8
      '{4'd8, 2'd3, 1'b0, 1'b0, 12'h000, 12'h000, 12'h044, 12'h000, 12'hFFF, 12'hFFF, 12'h000, 1'b1, 12'h044, 1'b0, 12'h000}, // R8
      '{4'd9, 2'd0, 1'b0, 1'b0, 12'h000, 12'h000, 12'h000, 12'h000, 12'hFFF, 12'hFFF, 12'h000, 1'b1, 12'hEEE, 1'b0, 12'h000}, // R9
      '{4'd10, 2'd1, 1'b0, 1'b0, 12'h123, 12'h000, 12'h222, 12'h000, 12'hFFF, 12'h000, 12'h022, 1'b0, 12'h123, 1'b0, 12'h000}, // R10
      '{4'd4, 2'd0, 1'b1, 1'b0, 12'h000, 12'h5A5, 12'h000, 12'h666, 12'hFFF, 12'hFFF, 12'h5A5, 1'b0, 12'h000, 1'b0, 12'h5A5}  // R4
   };

   task automatic chk(input string req, input string what,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [1:0] view, input logic pend,
                        input logic virt, input logic [11:0] ie, input logic [11:0] ip,
                        input logic [11:0] dlg, input logic [11:0] clm,
                        input logic [11:0] wd, input logic [11:0] wm);
      @(posedge clk);
      req_valid = v;      req_view = view;    req_pend = pend;  virt_on = virt;
      m_ie = XLEN'(ie);   m_ip = XLEN'(ip);   m_deleg = XLEN'(dlg);
      hw_claim = XLEN'(clm); req_wdata = XLEN'(wd); req_wmask = XLEN'(wm);
      @(negedge clk);
   endtask

   initial begin
      #(200_000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      req_valid = 1'b0; req_view = 2'd0; req_pend = 1'b0; virt_on = 1'b0;
      m_ie = '0; m_ip = '0; m_deleg = '0; hw_claim = '0; req_wdata = '0; req_wmask = '0;

      // start-up idle state, R10
      drive(1'b0, 2'd0, 1'b0, 1'b0, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000, 12'h000);
      chk("R10", "idle rd_data", rd_data, '0);
      chk("R10", "idle ie_we", XLEN'(ie_we), '0);
      chk("R10", "idle ip_we", XLEN'(ip_we), '0);

      for (int i = 0; i < NV; i++) begin
         string tg;
         tg = $sformatf("R%0d", TAB[i].tag);
         drive(1'b1, TAB[i].view, TAB[i].pend, TAB[i].virt, TAB[i].ie, TAB[i].ip,
               TAB[i].dlg, TAB[i].clm, TAB[i].wd, TAB[i].wm);
         chk(tg, $sformatf("vec%0d rd_data", i), rd_data, XLEN'(TAB[i].rd));
         chk(tg, $sformatf("vec%0d ie_we", i), XLEN'(ie_we), XLEN'(TAB[i].iewe));
         chk(tg, $sformatf("vec%0d ie_next", i), ie_next, XLEN'(TAB[i].ien));
         chk(tg, $sformatf("vec%0d ip_we", i), XLEN'(ip_we), XLEN'(TAB[i].ipwe));
         chk(tg, $sformatf("vec%0d ip_next", i), ip_next, XLEN'(TAB[i].ipn));
      end

      // R10: request-shaped inputs with valid low do nothing
      drive(1'b0, 2'd0, 1'b1, 1'b0, 12'h0F0, 12'h111, 12'h666, 12'h000, 12'hFFF, 12'hFFF);
      chk("R10", "invalid rd_data", rd_data, '0);
      chk("R10", "invalid ip_we", XLEN'(ip_we), '0);
      chk("R10", "invalid ip_next", ip_next, 32'h111);
      chk("R10", "invalid ie_next", ie_next, 32'h0F0);

      // R4: upper word bits outside the delegable set are untouched
      drive(1'b1, 2'd0, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 12'h000, 12'hFFF, 12'hFFF);
      req_wdata = '1; req_wmask = '1; m_ip = 32'hA000_0000;
      @(negedge clk);
      chk("R4", "wide ip_next", ip_next, 32'hA000_0666);

      // R11: no hypervisor support
      drive(1'b1, 2'd1, 1'b0, 1'b1, 12'h6E4, 12'h000, 12'h044, 12'h000, 12'h000, 12'h000);
      chk("R11", "no-hyp guest S read", n_rd, 32'h044);
      drive(1'b1, 2'd2, 1'b0, 1'b0, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'hFFF, 12'hFFF);
      chk("R11", "no-hyp H enable rd", n_rd, '0);
      chk("R11", "no-hyp H enable we", XLEN'(n_ie_we), '0);
      chk("R11", "no-hyp H enable next", n_ie_next, 32'hFFF);
      drive(1'b1, 2'd3, 1'b1, 1'b0, 12'h000, 12'h000, 12'h444, 12'h000, 12'hFFF, 12'hFFF);
      chk("R11", "no-hyp VS pend we", XLEN'(n_ip_we), '0);
      chk("R11", "no-hyp VS pend next", n_ip_next, '0);
      drive(1'b1, 2'd1, 1'b0, 1'b1, 12'h000, 12'h000, 12'h222, 12'h000, 12'h222, 12'hFFF);
      chk("R11", "no-hyp guest S write", n_ie_next, 32'h222);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule